// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. Bytes arrive on a ready/valid port and wait in a single holding register while the previous frame is shifted out. A line-control word, written through its own write strobe, selects the data length (5 to 8 bits), whether a parity bit is added, its sense (even, odd or a constant "stick" value), one or two stop bits, and a break request that parks the line low. A baud divisor input is copied into the active divisor only when the line-control word is written. The active divisor divides an external oversampling tick, and sixteen divided ticks make one bit time.

The controller is a six-state machine. IDLE holds the line high and leaves on one of two transitions: to BREAK when break is requested (break wins), or to START when a byte is held. START sends the low start bit and goes to DATA. DATA sends the data bits LSB first, then goes to PARITY if parity is enabled, otherwise to STOP. PARITY sends one bit and goes to STOP. STOP sends one or two high bits and returns to IDLE. BREAK drives the line low and returns to IDLE once break is cleared. The frame format is captured on the transition from IDLE to START. A write during a frame therefore only affects later frames.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, tx is high, busy is low, in_ready is high, the line-control word is all zeros and the active divisor is 1.
- R2: A frame is a low start bit, the data bits LSB first, an optional parity bit and then the stop bits. Each bit lasts 16 times the active divisor clock cycles when os_tick is held high.
- R3: Line-control bits [1:0] set the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused high bits of the byte are not sent.
- R4: When bit [2] (parity enable) is 0, no parity bit is sent, and bits [3] and [4] have no effect.
- R5: With bit [2] set and bit [4] clear, bit [3] = 1 gives even parity and bit [3] = 0 gives odd parity over the sent data bits.
- R6: With bits [2] and [4] set, the parity bit is the constant 1 when bit [3] is 0, and the constant 0 when bit [3] is 1.
- R7: Bit [5] = 0 gives one stop bit and bit [5] = 1 gives two stop bits.
- R8: When bit [6] (break) is set, tx goes low only after the frame in progress has ended, and it stays low with busy low for as long as break is set.
- R9: A byte held while break is set is kept. It is sent as the next frame after break is cleared.
- R10: div_in is copied into the active divisor only in a cycle where lcr_we is high. Changing div_in at other times has no effect on bit timing.
- R11: The line-control word is sampled at frame start, so a write during a frame leaves that frame unchanged and applies to the next one.
- R12: busy is high from the first cycle of the start bit through the last cycle of the final stop bit, and low in the cycle after it.
- R13: Only one byte is held. in_ready drops after a byte is accepted and rises again when that byte starts its frame, so one byte can be accepted while another is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Holding register empty |
| lcr_we | input | 1 | Line-control write strobe; also loads the divisor |
| lcr_wdata | input | 7 | Line-control word: [1:0] length, [2] parity enable, [3] even select, [4] stick, [5] two stop, [6] break |
| div_in | input | 16 | Baud divisor, copied on lcr_we |
| os_tick | input | 1 | Oversampling tick enable |
| tx | output | 1 | Serial transmit line |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume the producer holds in_valid only as a pulse while in_ready is high, and that the divisor loaded is nonzero (a zero is treated as 1). They also assume os_tick stays high, so that bit boundaries fall a whole number of cycles apart. The stimulus keeps to these assumptions: every byte is offered for exactly one cycle at a falling edge while the holding register is empty, the divisors used are 1, 2 and 3, and os_tick is tied high. Line-control writes in the middle of a frame are made at the centre of a data bit, well away from the frame edges.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W    = 8;
    localparam int BIT_TICKS = 16;

    typedef struct packed {
        logic       brk;
        logic       two_stop;
        logic       stick;
        logic       even;
        logic       par_en;
        logic [1:0] wlen;
    } lcr_t;

    localparam int LCR_W = $bits(lcr_t);

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_BREAK
    } tx_state_e;

    // Parity bit for the data bits actually sent under the given format.
    function automatic logic parity_bit(input lcr_t c, input logic [DATA_W-1:0] d);
        logic ones_odd;
        int   nbits;
        nbits    = 5 + int'(c.wlen);
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) ones_odd = ones_odd ^ d[i];
        end
        if (c.stick) return ~c.even;
        return c.even ? ones_odd : ~ones_odd;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             clr,
    output logic             sample_tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt;

    assign div_eff     = (div_q == '0) ? DIV_W'(1) : div_q;
    assign sample_tick = os_tick && (cnt >= div_eff - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
        end else if (load) begin
            div_q <= div_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (os_tick) begin
            cnt <= sample_tick ? '0 : cnt + DIV_W'(1);
        end
    end

    // R10: active divisor moves only on a line-control write
    a_r10_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(div_q));

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         take,
    output logic         hold_valid,
    output logic [W-1:0] hold_data
);

    assign in_ready = !hold_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (in_valid && in_ready) begin
            hold_valid <= 1'b1;
            hold_data  <= in_data;
        end else if (take) begin
            hold_valid <= 1'b0;
        end
    end

    // R13: one entry only; acceptance closes the port
    a_r13_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R13: the sequencer never takes from an empty register
    a_r13_take_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_valid);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              lcr_we,
    input  logic [LCR_W-1:0]  lcr_wdata,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              os_tick,
    output logic              tx,
    output logic              busy
);

    localparam int TICK_W = $clog2(BIT_TICKS);
    localparam int IDX_W  = $clog2(DATA_W);

    tx_state_e         state, state_nx;
    lcr_t              lcr_q;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              sample_tick;
    logic              bit_end;
    logic [TICK_W-1:0] tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic              stop_idx;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic [1:0]        cfg_wlen;
    logic              cfg_par_en;
    logic              cfg_two_stop;

    uart_tx_hold #(.W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .load        (lcr_we),
        .div_in      (div_in),
        .clr         (take),
        .sample_tick (sample_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lcr_q <= '0;
        else if (lcr_we) lcr_q <= lcr_t'(lcr_wdata);
    end

    assign take     = (state == S_IDLE) && !lcr_q.brk && hold_valid;
    assign bit_end  = sample_tick && (tick_cnt == TICK_W'(BIT_TICKS - 1));
    assign last_idx = IDX_W'(4) + IDX_W'(cfg_wlen);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (lcr_q.brk)       state_nx = S_BREAK;
                else if (hold_valid) state_nx = S_START;
            end
            S_START:  if (bit_end) state_nx = S_DATA;
            S_DATA: begin
                if (bit_end && bit_idx == last_idx)
                    state_nx = cfg_par_en ? S_PARITY : S_STOP;
            end
            S_PARITY: if (bit_end) state_nx = S_STOP;
            S_STOP: begin
                if (bit_end && (!cfg_two_stop || stop_idx)) state_nx = S_IDLE;
            end
            S_BREAK:  if (!lcr_q.brk) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q      <= '0;
            par_q        <= 1'b0;
            tick_cnt     <= '0;
            bit_idx      <= '0;
            stop_idx     <= 1'b0;
            cfg_wlen     <= '0;
            cfg_par_en   <= 1'b0;
            cfg_two_stop <= 1'b0;
        end else if (take) begin
            shift_q      <= hold_data;
            par_q        <= parity_bit(lcr_q, hold_data);
            tick_cnt     <= '0;
            bit_idx      <= '0;
            stop_idx     <= 1'b0;
            cfg_wlen     <= lcr_q.wlen;
            cfg_par_en   <= lcr_q.par_en;
            cfg_two_stop <= lcr_q.two_stop;
        end else if (busy && sample_tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + TICK_W'(1);
            if (bit_end && state == S_DATA) begin
                shift_q <= shift_q >> 1;
                bit_idx <= bit_idx + IDX_W'(1);
            end
            if (bit_end && state == S_STOP) stop_idx <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        tx   = 1'b1;
        busy = 1'b0;
        unique case (state)
            S_IDLE:   begin tx = 1'b1;       busy = 1'b0; end
            S_START:  begin tx = 1'b0;       busy = 1'b1; end
            S_DATA:   begin tx = shift_q[0]; busy = 1'b1; end
            S_PARITY: begin tx = par_q;      busy = 1'b1; end
            S_STOP:   begin tx = 1'b1;       busy = 1'b1; end
            S_BREAK:  begin tx = 1'b0;       busy = 1'b0; end
            default:  begin tx = 1'b1;       busy = 1'b0; end
        endcase
    end

    // R2: every frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);

    // R12: the last bit sent before busy falls is a high stop bit
    a_r12_end_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx));

    // R11: the captured format cannot move inside a frame
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_wlen) && $stable(cfg_par_en)
                                   && $stable(cfg_two_stop) && $stable(par_q)));

    // R9: break leaves the held byte untouched
    a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BREAK && $past(state == S_BREAK))
            |-> ($stable(hold_valid) && $stable(hold_data)));

    // R8: break never starts while a frame is on the line
    a_r8_break_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state != S_BREAK));

endmodule

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        lcr_we = 1'b0;
    logic [6:0]  lcr_wdata = '0;
    logic [15:0] div_in = 16'd1;
    logic        os_tick = 1'b1;
    logic        tx;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    uart_frame_tx i_uart_frame_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .lcr_we    (lcr_we),
        .lcr_wdata (lcr_wdata),
        .div_in    (div_in),
        .os_tick   (os_tick),
        .tx        (tx),
        .busy      (busy)
    );

    // {line-control[6:0], byte[7:0]}
    localparam logic [14:0] VEC [8] = '{
        {7'b0000011, 8'hA5},   // 8 bits, no parity, 1 stop
        {7'b0000111, 8'h3C},   // 8 bits, odd parity
        {7'b0001111, 8'h3D},   // 8 bits, even parity
        {7'b0100000, 8'hFF},   // 5 bits, two stop
        {7'b0010101, 8'h15},   // 6 bits, stick with even=0 -> 1
        {7'b0011110, 8'h7F},   // 7 bits, stick with even=1 -> 0
        {7'b0011011, 8'h81},   // parity off, even/stick set but ignored
        {7'b0101110, 8'h55}    // 7 bits, even parity, two stop
    };
    string VEC_TAG [8] = '{"R2", "R5", "R5", "R7", "R6", "R6", "R4", "R3"};

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected done");
            summary();
        end
    end

    task automatic tick();
        @(negedge clk);
        lcr_we   = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic write_lcr(input logic [6:0] l, input logic [15:0] d);
        @(negedge clk);
        lcr_wdata = l;
        div_in    = d;
        lcr_we    = 1'b1;
        tick();
    endtask

    task automatic push_byte(input logic [7:0] d);
        @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        tick();
    endtask

    // Expected bit sequence built from the requirement text
    function automatic int build(input logic [6:0] l, input logic [7:0] d,
                                 output logic [11:0] bits, output logic [11:0] is_par);
        int n, pos, ones;
        logic p;
        bits   = '1;
        is_par = '0;
        n      = 5 + int'(l[1:0]);
        bits[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            if (i < n) begin
                bits[1 + i] = d[i];
                if (d[i]) ones++;
            end
        end
        pos = 1 + n;
        if (l[2]) begin
            if (l[4]) p = ~l[3];
            else if (l[3]) p = (ones % 2) == 1;
            else p = (ones % 2) == 0;
            bits[pos]   = p;
            is_par[pos] = 1'b1;
            pos++;
        end
        bits[pos] = 1'b1;
        pos++;
        if (l[5]) begin
            bits[pos] = 1'b1;
            pos++;
        end
        return pos;
    endfunction

    task automatic frame_check(input logic [6:0] l, input logic [7:0] d, input int dv,
                               input string tag, input bit do_mid,
                               input logic [6:0] mid_lcr, input logic [7:0] mid_data);
        logic [11:0] bits, is_par;
        int len;
        string role;
        len = build(l, d, bits, is_par);
        while (tx !== 1'b1) tick();
        while (tx !== 1'b0) tick();
        check("R12", busy, 1'b1, {tag, " busy at start bit"});
        repeat (8 * dv - 1) tick();
        for (int b = 0; b < len; b++) begin
            if (b == 0) role = "R2";
            else if (is_par[b]) role = l[4] ? "R6" : "R5";
            else if (b <= 5 + int'(l[1:0])) role = "R3";
            else role = "R7";
            check(role, tx, bits[b], $sformatf("%s bit %0d", tag, b));
            check("R12", busy, 1'b1, $sformatf("%s busy in bit %0d", tag, b));
            if (do_mid && b == 2) begin
                lcr_wdata = mid_lcr;
                lcr_we    = 1'b1;
                in_data   = mid_data;
                in_valid  = 1'b1;
            end
            if (b < len - 1) repeat (16 * dv) tick();
        end
        repeat (8 * dv + 1) tick();
        check("R12", busy, 1'b0, {tag, " busy after last stop"});
        check("R7", tx, 1'b1, {tag, " line after frame"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", tx, 1'b1, "tx in reset");
        check("R1", busy, 1'b0, "busy in reset");
        rst_n = 1'b1;
        tick();
        check("R1", tx, 1'b1, "tx idle");
        check("R1", busy, 1'b0, "busy idle");
        check("R1", in_ready, 1'b1, "in_ready idle");

        // R1: reset format is 5 data bits, no parity, one stop, divisor 1
        push_byte(8'hE6);
        frame_check(7'b0000000, 8'hE6, 1, "R1", 1'b0, '0, '0);

        foreach (VEC[i]) begin
            write_lcr(VEC[i][14:8], 16'd1);
            push_byte(VEC[i][7:0]);
            frame_check(VEC[i][14:8], VEC[i][7:0], 1, VEC_TAG[i], 1'b0, '0, '0);
        end

        // R10: divisor follows only the line-control write
        write_lcr(7'b0000011, 16'd2);
        div_in = 16'd3;
        push_byte(8'hC3);
        frame_check(7'b0000011, 8'hC3, 2, "R10", 1'b0, '0, '0);
        write_lcr(7'b0000011, 16'd3);
        push_byte(8'h3A);
        frame_check(7'b0000011, 8'h3A, 3, "R10", 1'b0, '0, '0);

        // R11 and R13: mid-frame format change and a second byte held
        write_lcr(7'b0000011, 16'd1);
        push_byte(8'h96);
        frame_check(7'b0000011, 8'h96, 1, "R11", 1'b1, 7'b0001100, 8'h4B);
        check("R13", in_ready, 1'b0, "second byte held at frame end");
        frame_check(7'b0001100, 8'h4B, 1, "R11", 1'b0, '0, '0);
        check("R13", in_ready, 1'b1, "holding register empty again");

        // R8 and R9: break requested mid-frame with a byte waiting
        write_lcr(7'b0000011, 16'd1);
        push_byte(8'h0F);
        frame_check(7'b0000011, 8'h0F, 1, "R8", 1'b1, 7'b1000011, 8'hD2);
        repeat (5) tick();
        check("R8", tx, 1'b0, "line low in break");
        check("R8", busy, 1'b0, "busy low in break");
        check("R9", in_ready, 1'b0, "byte kept in break");
        repeat (60) tick();
        check("R8", tx, 1'b0, "line still low in break");
        check("R9", in_ready, 1'b0, "byte still kept");
        write_lcr(7'b0001111, 16'd1);
        frame_check(7'b0001111, 8'hD2, 1, "R9", 1'b0, '0, '0);
        check("R9", in_ready, 1'b1, "byte sent after break");

        summary();
    end

endmodule